// File: doc/BRIEF.md
# Dual-Channel Serial DAC Write Sequencer

This block sits on the host side of a two-channel, 12-bit, serial-input digital-to-analog converter. A single start pulse launches one operation. A write operation shifts a 16-bit word to the converter and then loads it into one channel, into both channels, or into neither. A clear operation forces both converter registers to zero-scale or to half-scale. The block drives every control pin of the converter and reports busy and done to the host.

A write word has 4 padding bits followed by the 12-bit code, most significant bit first. The serial clock comes from the system clock. Its high phase and its low phase each last a parameterized number of system cycles. The load strobes and the clear pulse also have parameterized widths. A write ends with a load-strobe phase. The load strobes are always released before the next word can start shifting. During a clear, the load strobes stay high while the clear line returns high, so shift-register contents are never transferred by accident.

Top module: `dac_load_seq`

## Requirements
- R1: A write sends exactly 16 bits, most significant first. The first 4 bits are zero padding; the next 12 are the code from bit 11 down to bit 0. The code is captured in the cycle the start is accepted.
- R2: The serial clock is high whenever chip select is high. The data line changes only in the cycle the serial clock falls. Each low phase lasts SCLK_LO_CYC cycles and each high phase lasts SCLK_HI_CYC cycles, so data is stable for at least one cycle before and after every rising edge.
- R3: Chip select goes low in the cycle after the start is accepted. All 16 rising serial clock edges occur while chip select is low. Chip select returns high at the end of the last high phase. No rising edge occurs while chip select is high.
- R4: Channel select bit 0 controls load strobe A and bit 1 controls load strobe B, and both are active low. After chip select rises, each strobe whose select bit is 0 is held low for LOAD_CYC cycles, and both strobes are then driven high. A select of 2'b11 produces no strobe.
- R5: Both load strobes are high whenever chip select is low.
- R6: A clear operation (op_reset_i = 1 at start) drives the level line to reset_half_i (1 = half-scale, 0 = zero-scale) one cycle before it pulls the clear line low. The clear line stays low for CLR_CYC cycles. The level is held steady and both load strobes are high throughout the pulse. No serial clock edge occurs.
- R7: Busy rises in the cycle after the start is accepted and falls in the cycle done pulses. Done is high for exactly one cycle. For a write, done occurs 16·(SCLK_LO_CYC+SCLK_HI_CYC) cycles after acceptance, plus LOAD_CYC unless the select is 2'b11. For a clear, it occurs 1+CLR_CYC cycles after acceptance.
- R8: A start while busy is ignored. The word, the strobes, the clear line and the timing of the running operation are unchanged.
- R9: While reset is asserted, chip select, serial clock, both load strobes and the clear line are high, and busy, done and the level line are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_reset_i | input | 1 | 1 selects a clear operation, 0 a write |
| reset_half_i | input | 1 | Clear level: 1 half-scale, 0 zero-scale |
| code_i | input | CODE_W | Code to write |
| chan_n_i | input | 2 | Active-low channel select (bit 0 A, bit 1 B) |
| dac_cs_n_o | output | 1 | Converter chip select, active low |
| dac_sclk_o | output | 1 | Serial clock, idles high |
| dac_sdo_o | output | 1 | Serial data to the converter |
| dac_load_a_n_o | output | 1 | Load strobe channel A, active low |
| dac_load_b_n_o | output | 1 | Load strobe channel B, active low |
| dac_clr_n_o | output | 1 | Clear line, active low |
| dac_half_o | output | 1 | Clear level line |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every result is due a fixed number of cycles after the accepting edge. For a write with the default 4-cycle phases, done comes after 128 cycles, or after 132 when a strobe is issued; for a clear, it comes after 5 cycles. The bench counts rising clock edges from the accepting edge to the first sample where done is high and compares that count with the value computed from the parameters. A monitor samples the pins on every falling system-clock edge. It rebuilds the word from the rising serial-clock edges, measures each phase, strobe and clear pulse in whole cycles, and keeps the results until the operation finishes, when they are compared with the expected values.

// File: rtl/dls_pkg.sv
package dls_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCLK_LO,
    ST_SCLK_HI,
    ST_LOAD,
    ST_CLR_SET,
    ST_CLR_LO
  } dls_state_e;
endpackage

// File: rtl/dls_timer.sv
module dls_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - CNT_W'(1);
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/dls_shifter.sv
module dls_shifter #(
  parameter int FRAME_W = 16,
  parameter int CODE_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [CODE_W-1:0] code,
  output logic              bit_out,
  output logic              last_bit
);
  localparam int PAD_W = FRAME_W - CODE_W;
  localparam int BC_W  = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [BC_W-1:0]    bc_q, bc_d;

  always_comb begin
    sr_d = sr_q;
    bc_d = bc_q;
    if (load) begin
      sr_d = {{PAD_W{1'b0}}, code};
      bc_d = BC_W'(FRAME_W - 1);
    end else if (advance) begin
      sr_d = {sr_q[FRAME_W-2:0], 1'b0};
      bc_d = bc_q - BC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      bc_q <= '0;
    end else begin
      sr_q <= sr_d;
      bc_q <= bc_d;
    end
  end

  assign bit_out  = sr_q[FRAME_W-1];
  assign last_bit = (bc_q == '0);
endmodule

// File: rtl/dls_ctrl.sv
module dls_ctrl
  import dls_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SCLK_HI_CYC = 4,
  parameter int SCLK_LO_CYC = 4,
  parameter int LOAD_CYC    = 4,
  parameter int CLR_CYC     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_reset,
  input  logic             reset_half,
  input  logic [1:0]       chan_n,
  input  logic             tmr_zero,
  input  logic             sh_last,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             sh_load,
  output logic             sh_adv,
  output logic             cs_n,
  output logic             sclk,
  output logic             load_a_n,
  output logic             load_b_n,
  output logic             clr_n,
  output logic             half,
  output logic             busy,
  output logic             done
);
  dls_state_e st_q, st_d;
  logic [1:0] sel_q, sel_d;
  logic cs_q, cs_d, sclk_q, sclk_d, lda_q, lda_d, ldb_q, ldb_d;
  logic clr_q, clr_d, half_q, half_d, busy_q, busy_d, done_q, done_d;

  always_comb begin
    st_d = st_q;   sel_d = sel_q;
    cs_d = cs_q;   sclk_d = sclk_q;
    lda_d = lda_q; ldb_d = ldb_q;
    clr_d = clr_q; half_d = half_q;
    busy_d = busy_q;
    done_d = 1'b0;
    tmr_load = 1'b0; tmr_val = '0;
    sh_load = 1'b0;  sh_adv = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        busy_d   = 1'b1;
        sel_d    = chan_n;
        tmr_load = 1'b1;
        if (op_reset) begin
          half_d  = reset_half;
          tmr_val = '0;
          st_d    = ST_CLR_SET;
        end else begin
          cs_d    = 1'b0;
          sclk_d  = 1'b0;
          sh_load = 1'b1;
          tmr_val = CNT_W'(SCLK_LO_CYC - 1);
          st_d    = ST_SCLK_LO;
        end
      end
      ST_SCLK_LO: if (tmr_zero) begin
        sclk_d   = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(SCLK_HI_CYC - 1);
        st_d     = ST_SCLK_HI;
      end
      ST_SCLK_HI: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (sh_last) begin
          cs_d = 1'b1;
          if (sel_q == 2'b11) begin
            busy_d = 1'b0;
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            lda_d   = sel_q[0];
            ldb_d   = sel_q[1];
            tmr_val = CNT_W'(LOAD_CYC - 1);
            st_d    = ST_LOAD;
          end
        end else begin
          sh_adv  = 1'b1;
          sclk_d  = 1'b0;
          tmr_val = CNT_W'(SCLK_LO_CYC - 1);
          st_d    = ST_SCLK_LO;
        end
      end
      ST_LOAD: if (tmr_zero) begin
        lda_d  = 1'b1;
        ldb_d  = 1'b1;
        busy_d = 1'b0;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      ST_CLR_SET: if (tmr_zero) begin
        clr_d    = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(CLR_CYC - 1);
        st_d     = ST_CLR_LO;
      end
      ST_CLR_LO: if (tmr_zero) begin
        clr_d  = 1'b1;
        busy_d = 1'b0;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  sel_q <= 2'b11;
      cs_q <= 1'b1;     sclk_q <= 1'b1;
      lda_q <= 1'b1;    ldb_q <= 1'b1;
      clr_q <= 1'b1;    half_q <= 1'b0;
      busy_q <= 1'b0;   done_q <= 1'b0;
    end else begin
      st_q <= st_d;     sel_q <= sel_d;
      cs_q <= cs_d;     sclk_q <= sclk_d;
      lda_q <= lda_d;   ldb_q <= ldb_d;
      clr_q <= clr_d;   half_q <= half_d;
      busy_q <= busy_d; done_q <= done_d;
    end
  end

  assign cs_n = cs_q;   assign sclk = sclk_q;
  assign load_a_n = lda_q; assign load_b_n = ldb_q;
  assign clr_n = clr_q; assign half = half_q;
  assign busy = busy_q; assign done = done_q;
endmodule

// File: rtl/dac_load_seq.sv
module dac_load_seq #(
  parameter int CODE_W      = 12,
  parameter int FRAME_W     = 16,
  parameter int SCLK_HI_CYC = 4,
  parameter int SCLK_LO_CYC = 4,
  parameter int LOAD_CYC    = 4,
  parameter int CLR_CYC     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_reset_i,
  input  logic              reset_half_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        chan_n_i,
  output logic              dac_cs_n_o,
  output logic              dac_sclk_o,
  output logic              dac_sdo_o,
  output logic              dac_load_a_n_o,
  output logic              dac_load_b_n_o,
  output logic              dac_clr_n_o,
  output logic              dac_half_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int MAX_A   = (SCLK_HI_CYC > SCLK_LO_CYC) ? SCLK_HI_CYC : SCLK_LO_CYC;
  localparam int MAX_B   = (LOAD_CYC > CLR_CYC) ? LOAD_CYC : CLR_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             tmr_load, tmr_zero, sh_load, sh_adv, sh_last;
  logic [CNT_W-1:0] tmr_val;

  dls_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  dls_shifter #(.FRAME_W(FRAME_W), .CODE_W(CODE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .advance(sh_adv), .code(code_i),
    .bit_out(dac_sdo_o), .last_bit(sh_last)
  );

  dls_ctrl #(
    .CNT_W(CNT_W), .SCLK_HI_CYC(SCLK_HI_CYC), .SCLK_LO_CYC(SCLK_LO_CYC),
    .LOAD_CYC(LOAD_CYC), .CLR_CYC(CLR_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start_i), .op_reset(op_reset_i),
    .reset_half(reset_half_i), .chan_n(chan_n_i), .tmr_zero(tmr_zero),
    .sh_last(sh_last), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .sh_load(sh_load), .sh_adv(sh_adv), .cs_n(dac_cs_n_o), .sclk(dac_sclk_o),
    .load_a_n(dac_load_a_n_o), .load_b_n(dac_load_b_n_o), .clr_n(dac_clr_n_o),
    .half(dac_half_o), .busy(busy_o), .done(done_o)
  );
endmodule

// File: rtl/dls_chk.sv
module dls_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic sdo,
  input logic lda_n,
  input logic ldb_n,
  input logic clr_n,
  input logic half,
  input logic busy,
  input logic done
);
  AST_SDO_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$fell(sclk)) |-> $stable(sdo)); // R2
  AST_SCLK_IDLE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk); // R2
  AST_STROBES_OFF_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (lda_n && ldb_n)); // R5
  AST_STROBES_OFF_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (lda_n && ldb_n && cs_n)); // R6
  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> $stable(half)); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_FRAME_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n || !clr_n) |-> busy); // R7
endmodule

bind dac_load_seq dls_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(dac_cs_n_o), .sclk(dac_sclk_o), .sdo(dac_sdo_o),
  .lda_n(dac_load_a_n_o), .ldb_n(dac_load_b_n_o), .clr_n(dac_clr_n_o),
  .half(dac_half_o), .busy(busy_o), .done(done_o)
);

// File: tb/dac_load_seq_tb.sv
module dac_load_seq_tb;
  localparam int HI = 4, LO = 4, LDW = 4, CLRW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, op_reset_i = 1'b0, reset_half_i = 1'b0;
  logic [11:0] code_i = '0;
  logic [1:0]  chan_n_i = 2'b11;
  logic cs_n, sclk, sdo, lda_n, ldb_n, clr_n, half, busy, done;

  int checks = 0, fails = 0;

  dac_load_seq #(.SCLK_HI_CYC(HI), .SCLK_LO_CYC(LO), .LOAD_CYC(LDW), .CLR_CYC(CLRW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_reset_i(op_reset_i),
    .reset_half_i(reset_half_i), .code_i(code_i), .chan_n_i(chan_n_i),
    .dac_cs_n_o(cs_n), .dac_sclk_o(sclk), .dac_sdo_o(sdo),
    .dac_load_a_n_o(lda_n), .dac_load_b_n_o(ldb_n), .dac_clr_n_o(clr_n),
    .dac_half_o(half), .busy_o(busy), .done_o(done)
  );

  always #5 clk = ~clk;

  // monitor state
  logic [15:0] bits;
  int nrise, run, cs_err, wid_err, dat_err, a_cnt, b_cnt, stb_err, r_cnt, r_err, lvl_err;
  logic p_sclk = 1'b1, p_cs = 1'b1, p_sdo = 1'b0, exp_lvl = 1'b0;

  task automatic mon_clear();
    bits = '0; nrise = 0; cs_err = 0; wid_err = 0; dat_err = 0;
    a_cnt = 0; b_cnt = 0; stb_err = 0; r_cnt = 0; r_err = 0; lvl_err = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk && !p_sclk) begin
        if (cs_n) cs_err++;
        else begin
          bits = {bits[14:0], sdo};
          nrise++;
          if (run != LO) wid_err++;
        end
      end
      if (!sclk && p_sclk && !p_cs && run != HI) wid_err++;
      if (sclk == p_sclk) run++; else run = 1;
      if (cs_n && !sclk) wid_err++;
      if (!cs_n && (sdo != p_sdo) && !(p_sclk && !sclk)) dat_err++;
      if (!lda_n) begin a_cnt++; if (!cs_n) stb_err++; end
      if (!ldb_n) begin b_cnt++; if (!cs_n) stb_err++; end
      if (!clr_n) begin
        r_cnt++;
        if (!lda_n || !ldb_n) r_err++;
        if (half != exp_lvl) lvl_err++;
      end
      p_sclk = sclk; p_cs = cs_n; p_sdo = sdo;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int write_cycles(input logic [1:0] sel);
    return 16 * (LO + HI) + ((sel == 2'b11) ? 0 : LDW);
  endfunction

  task automatic run_op(input bit is_clr, input bit lvl, input logic [11:0] code,
                        input logic [1:0] sel, input bit intrude);
    int n, t;
    bit got;
    @(negedge clk); #1;
    mon_clear();
    exp_lvl = lvl;
    op_reset_i = is_clr; reset_half_i = lvl; code_i = code; chan_n_i = sel;
    start_i = 1'b1;
    n = 0; got = 0;
    while (n < 1000 && !got) begin
      @(posedge clk); @(negedge clk);
      n++;
      start_i = intrude && (n == 20);
      if (intrude && n == 20) begin
        op_reset_i = ~is_clr; code_i = ~code; chan_n_i = ~sel; reset_half_i = ~lvl;
      end
      if (done) got = 1;
    end
    #1;
    t = is_clr ? (1 + CLRW) : write_cycles(sel);
    chk(got && n == t + 1, "R7 done latency", n, t + 1);
    chk(!busy, "R7 busy low at done", busy, 0);
    if (is_clr) begin
      chk(r_cnt == CLRW, "R6 clear width", r_cnt, CLRW);
      chk(r_err == 0, "R6 strobes high in clear", r_err, 0);
      chk(lvl_err == 0 && half == lvl, "R6 level", half, lvl);
      chk(nrise == 0, "R6 no serial clock", nrise, 0);
    end else begin
      chk(nrise == 16, "R3 rising edges in frame", nrise, 16);
      chk(bits == {4'b0000, code}, "R1 frame content", bits, {4'b0000, code});
      chk(cs_err == 0, "R3 edges outside select", cs_err, 0);
      chk(wid_err == 0 && dat_err == 0, "R2 phase/data timing", wid_err + dat_err, 0);
      chk(a_cnt == (sel[0] ? 0 : LDW), "R4 strobe A", a_cnt, sel[0] ? 0 : LDW);
      chk(b_cnt == (sel[1] ? 0 : LDW), "R4 strobe B", b_cnt, sel[1] ? 0 : LDW);
      chk(stb_err == 0, "R5 strobes high in frame", stb_err, 0);
      if (intrude) chk(r_cnt == 0, "R8 intruding start ignored", r_cnt, 0);
    end
    @(negedge clk);
    chk(!done && !busy, "R7 idle after done", done, 0);
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240607);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(cs_n && sclk && lda_n && ldb_n && clr_n, "R9 reset high lines",
        {cs_n, sclk, lda_n, ldb_n, clr_n}, 5'b11111);
    chk(!busy && !done && !half, "R9 reset low lines", {busy, done, half}, 3'b000);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && cs_n && sclk, "R9 idle after release", {busy, cs_n, sclk}, 3'b011);

    run_op(0, 0, 12'hFFF, 2'b00, 0);
    run_op(0, 0, 12'h0A5, 2'b10, 0);
    run_op(0, 0, 12'h800, 2'b01, 0);
    run_op(0, 0, 12'h000, 2'b11, 0);
    run_op(0, 0, 12'h5A3, 2'b11, 0);
    run_op(1, 1, 12'h000, 2'b00, 0);
    run_op(1, 0, 12'h000, 2'b00, 0);
    run_op(0, 0, 12'h3C7, 2'b00, 1);
    run_op(1, 1, 12'h123, 2'b00, 1);
    for (int i = 0; i < 25; i++) begin
      bit c;
      c = ($urandom % 5) == 0;
      run_op(c, 1'($urandom), 12'($urandom), 2'($urandom), ($urandom % 4) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule